// File: doc/BRIEF.md
# GPIO Bank with Pin Interrupt Detection

This block is one bank of general-purpose pins behind a small word-addressed register port. For every pin it holds an output-enable bit, an output value, an alternate-function select and an interrupt mask. It drives these straight onto pad-side vectors. Pin inputs are brought into the clock domain through a synchronizer. They are then watched for a per-pin trigger condition.

Three bitmaps choose each pin's trigger: one picks edge or level detection, one picks the edge direction and one picks the active level. Events are latched in a sticky status register. A single request line goes high while any status bit is set on a pin whose mask bit is clear. Software clears every status bit at once by writing zero to the status offset. Status bits latch whether or not the pin is masked, so a pin can be polled without raising the request.

Top module: `gpio_irq_bank`

## Requirements
- R1: Offset 0 is the direction register: bit i set to 1 makes pin i an output, and `pinOe` follows it. Offset 1 is the output latch, driven on `pinOut`. Both read back what was written, and the write takes effect on the clock edge that samples it.
- R2: Offset 2 is the alternate-function register, one bit per pin. It is read/write and drives `pinAlt`.
- R3: Offset 3 is the interrupt mask, where 1 masks a pin. It resets to all ones. `irqReq` is high exactly while some status bit is set and that pin's mask bit is 0.
- R4: Offset 4 selects the trigger type per pin, with 1 meaning edge. For an edge pin, the bit at offset 5 chooses rising (1) or falling (0). The input goes through two synchronizing flops and is compared with the previous synchronized sample. A pin change applied before clock edge k shows in the status register after edge k+2.
- R5: For a level pin (offset 4 bit 0), the bit at offset 6 chooses active-high (1) or active-low (0). The status bit sets on every edge at which the synchronized input is at that level.
- R6: Offset 7 is the sticky status register. Writing 0 to it clears all bits. Writing any non-zero value has no effect.
- R7: When a clearing write and a new event reach the same edge, the new event's status bit ends up set.
- R8: Offset 8 returns the synchronized live pin levels, which lag `pinIn` by two edges. Writes to offset 8 are ignored.
- R9: A status bit sets when its condition occurs even if the pin is masked. The mask gates only `irqReq`.
- R10: After reset, every register except the mask reads 0. Offsets 9 to 15 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Write strobe for the register port |
| regAddr | input | 4 | Word offset of the accessed register |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data for `regAddr`, combinational |
| pinIn | input | 16 | Pad input levels, asynchronous |
| pinOut | output | 16 | Output latch to the pads |
| pinOe | output | 16 | Output enables, from the direction register |
| pinAlt | output | 16 | Alternate-function selects |
| irqReq | output | 1 | Summary interrupt request |

## Verification
The assertions take for granted that at most one register write arrives per cycle. They also assume `pinIn` is held stable around the sampling edge, so the synchronizer output is deterministic. The stimulus changes pins and register-port inputs only a short time after a rising edge, and it issues one write per cycle. Clearing writes are lined up on purpose with the edge on which a synchronized event arrives.

// File: rtl/gib_pkg.sv
package gib_pkg;

  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    OFS_DIR  = 4'd0,
    OFS_OUT  = 4'd1,
    OFS_ALT  = 4'd2,
    OFS_MASK = 4'd3,
    OFS_TRIG = 4'd4,
    OFS_EDGE = 4'd5,
    OFS_LVL  = 4'd6,
    OFS_STAT = 4'd7,
    OFS_PINS = 4'd8
  } regOfs_t;

  // write strobes from control to datapath
  typedef struct packed {
    logic wrDir;
    logic wrOut;
    logic wrAlt;
    logic wrMask;
    logic wrTrig;
    logic wrEdge;
    logic wrLvl;
    logic clrStatus;
  } bankStrobes_t;

endpackage

// File: rtl/gib_ctrl.sv
module gib_ctrl
  import gib_pkg::*;
#(
  parameter int PIN_COUNT = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [PIN_COUNT-1:0] regWrData,
  output bankStrobes_t         stb,
  output regOfs_t              rdSel,
  output logic                 rdValid
);

  logic wrDataZero;
  assign wrDataZero = (regWrData == '0);

  always_comb begin
    stb     = '0;
    rdSel   = regOfs_t'(regAddr);
    rdValid = (regAddr <= ADDR_W'(OFS_PINS));
    if (regWrEn) begin
      case (regAddr)
        OFS_DIR:  stb.wrDir     = 1'b1;
        OFS_OUT:  stb.wrOut     = 1'b1;
        OFS_ALT:  stb.wrAlt     = 1'b1;
        OFS_MASK: stb.wrMask    = 1'b1;
        OFS_TRIG: stb.wrTrig    = 1'b1;
        OFS_EDGE: stb.wrEdge    = 1'b1;
        OFS_LVL:  stb.wrLvl     = 1'b1;
        OFS_STAT: stb.clrStatus = wrDataZero;
        default:  stb           = '0;
      endcase
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb)); // R10

  AST_NO_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !regWrEn |-> (stb == '0)); // R8

endmodule

// File: rtl/gib_datapath.sv
module gib_datapath
  import gib_pkg::*;
#(
  parameter int PIN_COUNT   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  bankStrobes_t         stb,
  input  regOfs_t              rdSel,
  input  logic                 rdValid,
  input  logic [PIN_COUNT-1:0] wrData,
  input  logic [PIN_COUNT-1:0] pinIn,
  output logic [PIN_COUNT-1:0] rdData,
  output logic [PIN_COUNT-1:0] pinOut,
  output logic [PIN_COUNT-1:0] pinOe,
  output logic [PIN_COUNT-1:0] pinAlt,
  output logic                 irqReq
);

  localparam logic [PIN_COUNT-1:0] ALL_ONES = {PIN_COUNT{1'b1}};

  logic [PIN_COUNT-1:0] dirReg, outReg, altReg, maskReg;
  logic [PIN_COUNT-1:0] trigReg, edgeReg, lvlReg, statusReg;
  logic [PIN_COUNT-1:0] syncStage [SYNC_STAGES];
  logic [PIN_COUNT-1:0] pinLive, pinPrev;
  logic [PIN_COUNT-1:0] eventVec, statusNext;

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirReg  <= '0;
      outReg  <= '0;
      altReg  <= '0;
      maskReg <= ALL_ONES;
      trigReg <= '0;
      edgeReg <= '0;
      lvlReg  <= '0;
    end else begin
      if (stb.wrDir)  dirReg  <= wrData;
      if (stb.wrOut)  outReg  <= wrData;
      if (stb.wrAlt)  altReg  <= wrData;
      if (stb.wrMask) maskReg <= wrData;
      if (stb.wrTrig) trigReg <= wrData;
      if (stb.wrEdge) edgeReg <= wrData;
      if (stb.wrLvl)  lvlReg  <= wrData;
    end
  end

  // input synchronizer and previous-sample register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncStage[s] <= '0;
      pinPrev <= '0;
    end else begin
      syncStage[0] <= pinIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncStage[s] <= syncStage[s-1];
      pinPrev <= pinLive;
    end
  end

  assign pinLive = syncStage[SYNC_STAGES-1];

  // per-pin trigger condition
  for (genvar b = 0; b < PIN_COUNT; b++) begin : g_pin
    logic riseHit, fallHit, levelHit;
    assign riseHit  = pinLive[b] & ~pinPrev[b];
    assign fallHit  = ~pinLive[b] & pinPrev[b];
    assign levelHit = ~(pinLive[b] ^ lvlReg[b]);
    assign eventVec[b] = trigReg[b] ? (edgeReg[b] ? riseHit : fallHit) : levelHit;
  end

  // sticky status, new events win over a clear
  assign statusNext = (stb.clrStatus ? '0 : statusReg) | eventVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusReg <= '0;
    else       statusReg <= statusNext;
  end

  assign irqReq = |(statusReg & ~maskReg);
  assign pinOut = outReg;
  assign pinOe  = dirReg;
  assign pinAlt = altReg;

  always_comb begin
    rdData = '0;
    if (rdValid) begin
      case (rdSel)
        OFS_DIR:  rdData = dirReg;
        OFS_OUT:  rdData = outReg;
        OFS_ALT:  rdData = altReg;
        OFS_MASK: rdData = maskReg;
        OFS_TRIG: rdData = trigReg;
        OFS_EDGE: rdData = edgeReg;
        OFS_LVL:  rdData = lvlReg;
        OFS_STAT: rdData = statusReg;
        OFS_PINS: rdData = pinLive;
        default:  rdData = '0;
      endcase
    end
  end

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    (stb.clrStatus && eventVec == '0) |=> (statusReg == '0)); // R6

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !stb.clrStatus |=> ((statusReg & $past(statusReg)) == $past(statusReg))); // R6

  AST_EVENT_LATCHED: assert property (@(posedge clk) disable iff (!rstN)
    (eventVec != '0) |=> ((statusReg & $past(eventVec)) == $past(eventVec))); // R7

  AST_FULL_MASK_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (maskReg == ALL_ONES) |-> !irqReq); // R3

  AST_OE_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrDir |=> (pinOe == $past(wrData))); // R1

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gib_pkg::*;
#(
  parameter int PIN_COUNT   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [PIN_COUNT-1:0] regWrData,
  output logic [PIN_COUNT-1:0] regRdData,
  input  logic [PIN_COUNT-1:0] pinIn,
  output logic [PIN_COUNT-1:0] pinOut,
  output logic [PIN_COUNT-1:0] pinOe,
  output logic [PIN_COUNT-1:0] pinAlt,
  output logic                 irqReq
);

  bankStrobes_t stb;
  regOfs_t      rdSel;
  logic         rdValid;

  gib_ctrl #(.PIN_COUNT(PIN_COUNT)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .stb       (stb),
    .rdSel     (rdSel),
    .rdValid   (rdValid)
  );

  gib_datapath #(.PIN_COUNT(PIN_COUNT), .SYNC_STAGES(SYNC_STAGES)) i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .rdSel   (rdSel),
    .rdValid (rdValid),
    .wrData  (regWrData),
    .pinIn   (pinIn),
    .rdData  (regRdData),
    .pinOut  (pinOut),
    .pinOe   (pinOe),
    .pinAlt  (pinAlt),
    .irqReq  (irqReq)
  );

endmodule

// File: tb/test_gpio_irq_bank.sv
module test_gpio_irq_bank;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [3:0]  regAddr = 4'd0;
  logic [15:0] regWrData = 16'h0;
  logic [15:0] regRdData;
  logic [15:0] pinIn = 16'h0;
  logic [15:0] pinOut, pinOe, pinAlt;
  logic        irqReq;

  int checks = 0;
  int errors = 0;
  bit armed = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  gpio_irq_bank i_gpio_irq_bank (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe), .pinAlt(pinAlt), .irqReq(irqReq)
  );

  // behavioural reference model
  logic [15:0] mDir, mOut, mAlt, mMask, mTrig, mEdge, mLvl, mStat;
  logic [15:0] seen[$];  // pin samples, newest first

  always @(posedge clk) begin
    logic [15:0] ev;
    logic [15:0] live, prev;
    if (!rstN) begin
      mDir = 0; mOut = 0; mAlt = 0; mMask = 16'hFFFF;
      mTrig = 0; mEdge = 0; mLvl = 0; mStat = 0;
      seen = '{16'h0, 16'h0, 16'h0};
      armed = 1;
    end else begin
      live = seen[1];
      prev = seen[2];
      for (int i = 0; i < 16; i++) begin
        if (mTrig[i]) ev[i] = mEdge[i] ? (live[i] && !prev[i]) : (!live[i] && prev[i]);
        else          ev[i] = (live[i] == mLvl[i]);
      end
      if (regWrEn && regAddr == 4'd7 && regWrData == 16'h0) mStat = ev;
      else mStat = mStat | ev;
      if (regWrEn) begin
        case (regAddr)
          4'd0: mDir  = regWrData;
          4'd1: mOut  = regWrData;
          4'd2: mAlt  = regWrData;
          4'd3: mMask = regWrData;
          4'd4: mTrig = regWrData;
          4'd5: mEdge = regWrData;
          4'd6: mLvl  = regWrData;
          default: ;
        endcase
      end
      seen.push_front(pinIn);
      void'(seen.pop_back());
    end
  end

  function automatic logic [15:0] expRead(input logic [3:0] a);
    case (a)
      4'd0: return mDir;
      4'd1: return mOut;
      4'd2: return mAlt;
      4'd3: return mMask;
      4'd4: return mTrig;
      4'd5: return mEdge;
      4'd6: return mLvl;
      4'd7: return mStat;
      4'd8: return seen[1];
      default: return 16'h0;
    endcase
  endfunction

  function automatic string readTag(input logic [3:0] a);
    case (a)
      4'd0, 4'd1: return "R1";
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4, 4'd5: return "R4";
      4'd6: return "R5";
      4'd7: return "R6";
      4'd8: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    if (armed && !done) begin
      logic [15:0] er;
      logic ei;
      er = expRead(regAddr);
      ei = |(mStat & ~mMask);
      check(regRdData === er, readTag(regAddr), regRdData, er);
      check(pinOe === mDir, "R1", pinOe, mDir);
      check(pinOut === mOut, "R1", pinOut, mOut);
      check(pinAlt === mAlt, "R2", pinAlt, mAlt);
      check(irqReq === ei, "R3 R9", {15'h0, irqReq}, {15'h0, ei});
    end
  end

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    regWrEn = 1; regAddr = a; regWrData = d;
    step(1);
    regWrEn = 0;
  endtask

  task automatic rd(input logic [3:0] a);
    regAddr = a;
    step(1);
  endtask

  initial begin
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    // R10: reset values, scanned during reset
    for (int a = 0; a < 16; a++) rd(4'(a));
    rstN = 1;
    // R9: pins low with level-low default set status though masked
    rd(4'd7); rd(4'd7); rd(4'd7);
    // R1, R2 configuration
    wr(4'd0, 16'hA5A5); wr(4'd1, 16'h3C3C); wr(4'd2, 16'h0F0F);
    rd(4'd0); rd(4'd1); rd(4'd2);
    // R4: low byte rising, high byte falling
    wr(4'd5, 16'h00FF); wr(4'd4, 16'hFFFF);
    step(2);
    wr(4'd7, 16'h0000); rd(4'd7);
    pinIn = 16'h00F0; rd(4'd8); rd(4'd8); rd(4'd7); rd(4'd7);
    wr(4'd3, 16'h0000); rd(4'd7);  // R3 unmask
    wr(4'd7, 16'h0000);
    pinIn = 16'h0000; step(4); rd(4'd7);
    pinIn = 16'hF000; step(4);
    pinIn = 16'h0000; step(4); rd(4'd7);
    // R6: non-zero write ignored
    wr(4'd7, 16'h1234); rd(4'd7);
    // R8 and R10: writes to read-only and unmapped offsets ignored
    wr(4'd8, 16'hFFFF); rd(4'd8);
    wr(4'd9, 16'hFFFF); wr(4'd15, 16'h5555); rd(4'd9); rd(4'd15);
    for (int a = 0; a < 9; a++) rd(4'(a));
    // R7: clearing write meets an arriving rising edge on bit 0
    wr(4'd7, 16'h0000); step(1);
    pinIn = 16'h0001; step(2);
    wr(4'd7, 16'h0000); rd(4'd7); rd(4'd7);
    // R5: level mode, active high then active low
    wr(4'd4, 16'h0000); wr(4'd6, 16'hFFFF);
    wr(4'd7, 16'h0000);
    pinIn = 16'h8421; step(3); wr(4'd7, 16'h0000); rd(4'd7);
    wr(4'd6, 16'h0000); pinIn = 16'hFF00; step(3); wr(4'd7, 16'h0000); rd(4'd7);
    wr(4'd3, 16'hFF00); rd(4'd7);  // R3 partial mask
    // mixed traffic
    for (int k = 0; k < 600; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      pinIn = (lfsr[3:0] == 0) ? ~pinIn : pinIn ^ (16'h1 << lfsr[7:4]);
      regAddr = lfsr[11:8];
      if (lfsr[12] && lfsr[13]) begin
        regWrEn = 1;
        regWrData = (lfsr[14] && regAddr == 4'd7) ? 16'h0 : {lfsr[7:0], lfsr[15:8]};
      end else regWrEn = 0;
      step(1);
    end
    regWrEn = 0;
    step(2);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule